// File: doc/BRIEF.md
# Dual-Modulus Prescaled Feedback Divider

This block divides a fast clock by a programmable integer and emits one single-cycle pulse per period. It is meant to feed the feedback input of a phase-frequency detector. A short prescaler runs in front of two slow counters. The prescaler divides by 6 or 7. A swallow counter decides how many prescaler periods use the long length. A main counter sets how many prescaler periods make up one output period. A doubling control switches the prescaler to 12/14, which makes all the even moduli above the normal range reachable. The prescaler is the only part that has to run at the full clock rate; the swallow and main counters change state once per prescaler period.

A separate reference divider counts the same clock and produces its own single-cycle pulse, with a modulus of its field value plus one. A jam input clears both dividers and holds them in their load state. Divider fields are taken only when a period starts, so reprogramming never shortens or stretches a period that is already running.

Top module: `dmp_fb_divider`

## Requirements
- R1: With doubling off and a nonzero swallow value A (A ≤ M), the feedback period is 6·(M+1)+A clock cycles. Examples: A=1, M=5 gives 37; A=3, M=10 gives 69.
- R2: With A = 0, every prescaler period uses the long length, so the feedback period is 7·(M+1). Examples: M=5 gives 42; M=0 gives 7, which is the smallest modulus.
- R3: With dbl_i high, the prescaler lengths become 12 and 14, so the feedback period is 2·(6·(M+1)+A). Example: A=1, M=5 gives 74.
- R4: The range ends are reachable. A=1, M=5 gives 37. A=7, M=63 gives 391. The same setting with doubling gives 782.
- R5: fb_pulse_o is high for exactly one clock cycle per period.
- R6: The fields are sampled only at the clock edge where a period begins. A change in the middle of a period leaves that period's length unchanged, and the next period uses the new values. A change made in the cycle just before the reload edge is taken at that edge.
- R7: The reference period is ref_div_i+1 cycles, so 4 gives 5 and 127 gives 128. With ref_div_i = 0, ref_pulse_o stays high on every cycle.
- R8: While jam_i is high, both outputs are low from the next cycle on. After jam_i falls, the first clock edge loads the fields. The first feedback pulse is visible N edges later, and the first reference pulse is visible ref_div_i+1 edges later.
- R9: During reset, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| jam_i | input | 1 | Clears and holds both dividers |
| swallow_i | input | A_W (4) | Number of long prescaler periods, A |
| main_i | input | M_W (6) | Main count M; the period holds M+1 prescaler periods |
| ref_div_i | input | R_W (7) | Reference modulus minus one |
| dbl_i | input | 1 | Doubles both prescaler lengths |
| fb_pulse_o | output | 1 | One-cycle feedback pulse every N cycles |
| ref_pulse_o | output | 1 | One-cycle reference pulse every ref_div_i+1 cycles |

## Verification
Two events can fall in the same clock cycle: the end-of-period reload, and a change to the divider fields. The bench uses the known period to count cycles from a feedback pulse. It changes the fields in the last cycle before the reload edge. It then checks two things: the pulse still arrives at the old period, and the following interval matches the new setting. A second test changes the fields in the middle of a period and applies the same two checks. This separates correct sampling at the reload point from both early and late capture.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

  typedef enum logic {
    CYC_SHORT = 1'b0,
    CYC_LONG  = 1'b1
  } psc_cyc_e;

  // Prescaler period length in clocks for a given cycle kind and doubling.
  function automatic int psc_len(input psc_cyc_e kind, input logic dbl, input int base);
    int n;
    n = (kind == CYC_LONG) ? base + 1 : base;
    return dbl ? 2 * n : n;
  endfunction

endpackage

// File: rtl/dmp_prescaler.sv
module dmp_prescaler
  import dmp_pkg::*;
#(
  parameter int PSC_BASE = 6
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     run_i,
  input  psc_cyc_e kind_i,
  input  logic     dbl_i,
  output logic     wrap_o
);
  localparam int LEN_MAX = 2 * (PSC_BASE + 1);
  localparam int CNT_W   = $clog2(LEN_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_val;

  assign wrap_o     = run_i && (cnt_q == '0);
  assign reload_val = CNT_W'(psc_len(kind_i, dbl_i, PSC_BASE) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || wrap_o)   cnt_q <= reload_val;
    else                         cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/dmp_swallow.sv
module dmp_swallow
  import dmp_pkg::*;
#(
  parameter int A_W = 4,
  parameter int M_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           wrap_i,
  input  logic [A_W-1:0] swallow_i,
  input  logic [M_W-1:0] main_i,
  input  logic           dbl_i,
  output logic           term_o,
  output psc_cyc_e       kind_nxt_o,
  output logic           dbl_nxt_o
);
  logic [A_W-1:0] a_cnt_q;
  logic [M_W-1:0] m_cnt_q;
  logic           a_zero_q;
  logic           dbl_q;
  logic           load;

  assign term_o = wrap_i && (m_cnt_q == '0);
  assign load   = !run_i || term_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_cnt_q  <= '0;
      m_cnt_q  <= '0;
      a_zero_q <= 1'b1;
      dbl_q    <= 1'b0;
    end else if (load) begin
      a_cnt_q  <= swallow_i;
      m_cnt_q  <= main_i;
      a_zero_q <= (swallow_i == '0);
      dbl_q    <= dbl_i;
    end else if (wrap_i) begin
      if (a_cnt_q != '0) a_cnt_q <= a_cnt_q - 1'b1;
      m_cnt_q <= m_cnt_q - 1'b1;
    end
  end

  // First prescaler period of a frame is always long; later ones are long
  // while swallows remain, or throughout when A is zero.
  always_comb begin
    if (load)                                      kind_nxt_o = CYC_LONG;
    else if (a_zero_q || (a_cnt_q > A_W'(1)))      kind_nxt_o = CYC_LONG;
    else                                           kind_nxt_o = CYC_SHORT;
  end

  assign dbl_nxt_o = load ? dbl_i : dbl_q;

endmodule

// File: rtl/dmp_ref_div.sv
module dmp_ref_div #(
  parameter int R_W = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [R_W-1:0] div_i,
  output logic           hit_o
);
  logic [R_W-1:0] cnt_q;

  assign hit_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || hit_o)   cnt_q <= div_i;
    else                        cnt_q <= cnt_q - 1'b1;
  end

endmodule

// File: rtl/dmp_fb_divider.sv
module dmp_fb_divider
  import dmp_pkg::*;
#(
  parameter int A_W      = 4,
  parameter int M_W      = 6,
  parameter int R_W      = 7,
  parameter int PSC_BASE = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           jam_i,
  input  logic [A_W-1:0] swallow_i,
  input  logic [M_W-1:0] main_i,
  input  logic [R_W-1:0] ref_div_i,
  input  logic           dbl_i,
  output logic           fb_pulse_o,
  output logic           ref_pulse_o
);
  logic     run_q;
  logic     wrap;
  logic     term;
  psc_cyc_e kind_nxt;
  logic     dbl_nxt;
  logic     ref_hit;
  logic     fb_q;
  logic     ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      fb_q  <= 1'b0;
      ref_q <= 1'b0;
    end else begin
      run_q <= !jam_i;
      fb_q  <= term && !jam_i;
      ref_q <= ref_hit && !jam_i;
    end
  end

  dmp_prescaler #(.PSC_BASE(PSC_BASE)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .kind_i (kind_nxt),
    .dbl_i  (dbl_nxt),
    .wrap_o (wrap)
  );

  dmp_swallow #(.A_W(A_W), .M_W(M_W)) u_swl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .wrap_i     (wrap),
    .swallow_i  (swallow_i),
    .main_i     (main_i),
    .dbl_i      (dbl_i),
    .term_o     (term),
    .kind_nxt_o (kind_nxt),
    .dbl_nxt_o  (dbl_nxt)
  );

  dmp_ref_div #(.R_W(R_W)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .div_i  (ref_div_i),
    .hit_o  (ref_hit)
  );

  assign fb_pulse_o  = fb_q;
  assign ref_pulse_o = ref_q;

endmodule

// File: rtl/dmp_fb_divider_chk.sv
module dmp_fb_divider_chk #(
  parameter int R_W = 7
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           jam_i,
  input logic [R_W-1:0] ref_div_i,
  input logic           fb_pulse_o,
  input logic           ref_pulse_o
);
  logic [3:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (jam_i) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (fb_pulse_o) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != 4'hf) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_FB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> !fb_pulse_o); // R5

  AST_JAM_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jam_i |=> (!fb_pulse_o && !ref_pulse_o)); // R8

  AST_FB_MIN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && fb_pulse_o) |-> (gap_q >= 4'd6)); // R2

  AST_REF_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_pulse_o && ($past(ref_div_i) == '0) && !jam_i) |=> ref_pulse_o); // R7

endmodule

bind dmp_fb_divider dmp_fb_divider_chk #(.R_W(R_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .jam_i       (jam_i),
  .ref_div_i   (ref_div_i),
  .fb_pulse_o  (fb_pulse_o),
  .ref_pulse_o (ref_pulse_o)
);

// File: tb/tb_dmp_fb_divider.sv
`timescale 1ns/1ps
module tb_dmp_fb_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       jam = 1'b0;
  logic       dbl = 1'b0;
  logic [3:0] a_f = '0;
  logic [5:0] m_f = '0;
  logic [6:0] r_f = '0;
  logic       fb;
  logic       rf;
  int         checks = 0;
  int         fails = 0;
  bit         finished = 1'b0;

  always #10 clk = ~clk;

  dmp_fb_divider dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .jam_i       (jam),
    .swallow_i   (a_f),
    .main_i      (m_f),
    .ref_div_i   (r_f),
    .dbl_i       (dbl),
    .fb_pulse_o  (fb),
    .ref_pulse_o (rf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_fields(input int a, input int m, input bit d, input int r);
    a_f = 4'(a); m_f = 6'(m); dbl = d; r_f = 7'(r);
  endtask

  task automatic restart(input int a, input int m, input bit d, input int r);
    @(negedge clk);
    set_fields(a, m, d, r);
    jam = 1'b1;
    repeat (2) @(negedge clk);
    jam = 1'b0;
  endtask

  // Negedges until the selected output is seen high; -1 on timeout.
  task automatic wait_hi(input bit sel_ref, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((sel_ref ? rf : fb) !== 1'b1) && n < 3000);
    if (n >= 3000) n = -1;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(fb == 1'b0, "R9 fb low in reset", int'(fb), 0);
    check(rf == 1'b0, "R9 ref low in reset", int'(rf), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_fb_period(input string req, input int a, input int m, input bit d, input int exp);
    int n;
    restart(a, m, d, 0);
    wait_hi(1'b0, n);
    @(negedge clk);
    check(fb == 1'b0, "R5 single-cycle pulse", int'(fb), 0);
    wait_hi(1'b0, n);
    check(n + 1 == exp, req, n + 1, exp);
  endtask

  task automatic t_ref_period(input int r, input int exp);
    int n;
    restart(1, 5, 1'b0, r);
    wait_hi(1'b1, n);
    wait_hi(1'b1, n);
    check(n == exp, "R7 reference period", n, exp);
  endtask

  task automatic t_ref_full();
    int highs;
    highs = 0;
    restart(1, 5, 1'b0, 0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (rf === 1'b1) highs++;
    end
    check(highs == 10, "R7 modulus one stays high", highs, 10);
  endtask

  task automatic t_jam();
    int first_fb;
    int first_rf;
    int bad;
    first_fb = -1; first_rf = -1; bad = 0;
    @(negedge clk);
    set_fields(1, 5, 1'b0, 9);
    jam = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (fb !== 1'b0 || rf !== 1'b0) bad++;
    end
    check(bad == 0, "R8 outputs quiet under jam", bad, 0);
    jam = 1'b0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (fb === 1'b1 && first_fb < 0) first_fb = k;
      if (rf === 1'b1 && first_rf < 0) first_rf = k;
    end
    check(first_fb == 38, "R8 first fb after jam", first_fb, 38);
    check(first_rf == 11, "R8 first ref after jam", first_rf, 11);
  endtask

  task automatic t_reprogram();
    int n;
    restart(1, 5, 1'b0, 0);
    wait_hi(1'b0, n);
    repeat (10) @(negedge clk);
    set_fields(0, 5, 1'b0, 0);
    wait_hi(1'b0, n);
    check(n + 10 == 37, "R6 running period kept", n + 10, 37);
    wait_hi(1'b0, n);
    check(n == 42, "R6 new period after reload", n, 42);
    repeat (41) @(negedge clk);
    set_fields(2, 6, 1'b0, 0);
    wait_hi(1'b0, n);
    check(n + 41 == 42, "R6 change at reload edge keeps pulse", n + 41, 42);
    wait_hi(1'b0, n);
    check(n == 44, "R6 change at reload edge taken", n, 44);
  endtask

  initial begin
    t_reset();
    t_fb_period("R1 A=1 M=5", 1, 5, 1'b0, 37);
    t_fb_period("R1 A=3 M=10", 3, 10, 1'b0, 69);
    t_fb_period("R2 A=0 M=5", 0, 5, 1'b0, 42);
    t_fb_period("R2 A=0 M=0", 0, 0, 1'b0, 7);
    t_fb_period("R3 doubled A=1 M=5", 1, 5, 1'b1, 74);
    t_fb_period("R4 top of range 391", 7, 63, 1'b0, 391);
    t_fb_period("R4 doubled top 782", 7, 63, 1'b1, 782);
    t_reprogram();
    t_ref_period(4, 5);
    t_ref_period(127, 128);
    t_ref_full();
    t_jam();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule